// File: doc/BRIEF.md
# IR Run-Length Receive Encoder

This block turns a demodulated infrared input into a stream of run-length bytes. On each sample strobe (one every 10 µs) it looks at the input level, once the optional inversion has been applied. It counts how many strobes the level stays the same. When the level changes, it packs the finished run into one byte and stores the byte in a small receive queue. A run longer than one byte can describe is cut into full-length chunks, and counting of the same level goes on after each chunk.

Software drains the queue through a small read-only register port. One address pops the oldest byte. A second address returns the data-available and overrun flags, and reading it clears the overrun flag. A third address returns the event identification bits. A receive event is raised while the queue holds at least half its depth. An error event is raised while the overrun flag is set. Each event has its own enable input. The interrupt line is the OR of the enabled events.

Top module: `irx_rle_rx`

## Requirements
- R1: Each stored byte has bit 7 set to 1 for a space (no IR) and 0 for a pulse, and bits 6:0 set to N, where the run lasted N+1 sample strobes (10 to 1280 µs). A byte is produced on the first strobe at which the level differs from the run in progress.
- R2: The input is only looked at on sample strobes. Level changes between strobes produce no byte and do not disturb the run count.
- R3: A run that lasts longer than 128 strobes produces one byte with N=127 for each full 128 strobes, and then a final byte with the remainder.
- R4: A run of exactly 128 strobes produces exactly one byte (N=127), and nothing is stored before the level changes.
- R5: When `ir_invert` is 1, the meaning of `ir_raw` is swapped before encoding. With `ir_invert` at 0, `ir_raw`=1 means a pulse.
- R6: The queue holds 16 bytes. A byte that arrives while the queue is full, with no pop in the same cycle, is dropped and sets the overrun flag. The 16 bytes already stored are kept.
- R7: Reading address 1 returns bit 0 = data available and bit 1 = overrun. The read returns the flag values from before the read, and then clears overrun.
- R8: Event bit 0 (value 0x01) is set while `ien_rx` is 1 and at least 8 bytes are stored.
- R9: Event bit 2 (value 0x04) is set while `ien_err` is 1 and overrun is set. `irq` is 1 exactly when some event bit is set.
- R10: While `rx_off` is 1, no new byte enters the queue.
- R11: Reading address 0 returns the oldest byte and pops it. When the queue is empty, the read returns 0x00 and has no effect. Reading address 2 returns the event bits.
- R12: After reset the queue is empty, overrun is clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | Sample strobe, one cycle wide, once per 10 µs |
| ir_raw | input | 1 | Demodulated IR input, asynchronous |
| ir_invert | input | 1 | Swap the meaning of the input |
| rx_off | input | 1 | Keep new bytes out of the queue |
| ien_rx | input | 1 | Enable for the receive-threshold event |
| ien_err | input | 1 | Enable for the overrun event |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address: 0 data, 1 flags, 2 events, 3 reads zero |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Interrupt, OR of the enabled events |

## Verification
`ir_raw` passes through a two-stage synchronizer, so the bench sets it three clock cycles before the next strobe. The strobe edge that closes a run registers the byte. The next edge writes it into the queue, so the flags and data can be read two edges after that strobe. The bench leaves at least two cycles after every strobe before any read. `rd_data` is combinational and is sampled one time unit after the falling edge at which the read is driven. A pop or a flag clear becomes visible at the following rising edge, and each later check reads after that edge.

// File: rtl/irx_pkg.sv
package irx_pkg;
  localparam int RUN_W  = 7;
  localparam int BYTE_W = RUN_W + 1;
  localparam int EVT_RX_BIT  = 0;
  localparam int EVT_ERR_BIT = 2;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_EVT  = 2'd2,
    REG_NONE = 2'd3
  } irx_reg_e;

  typedef struct packed {
    logic             space;
    logic [RUN_W-1:0] len;
  } irx_byte_t;
endpackage

// File: rtl/irx_in_sync.sv
module irx_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic inv,
  output logic lvl
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = din;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign lvl = sh_q[STAGES-1] ^ inv;
endmodule

// File: rtl/irx_run_enc.sv
module irx_run_enc
  import irx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      lvl,
  output logic      emit_vld,
  output irx_byte_t emit_byte
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             act_q, act_d;
  logic             cur_q, cur_d;
  logic [RUN_W-1:0] cnt_q, cnt_d;
  logic             vld_q, vld_d;
  irx_byte_t        byte_q, byte_d;

  always_comb begin
    act_d  = act_q;
    cur_d  = cur_q;
    cnt_d  = cnt_q;
    vld_d  = 1'b0;
    byte_d = byte_q;
    if (tick) begin
      if (!act_q) begin
        act_d = 1'b1;
        cur_d = lvl;
        cnt_d = '0;
      end else if (lvl != cur_q) begin
        vld_d  = 1'b1;
        byte_d = '{space: ~cur_q, len: cnt_q};
        cur_d  = lvl;
        cnt_d  = '0;
      end else if (cnt_q == RUN_MAX) begin
        vld_d  = 1'b1;
        byte_d = '{space: ~cur_q, len: cnt_q};
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cur_q  <= 1'b0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      act_q <= act_d;
      cur_q <= cur_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
      if (vld_d) byte_q <= byte_d;
    end
  end

  assign emit_vld  = vld_q;
  assign emit_byte = byte_q;
endmodule

// File: rtl/irx_fifo.sv
module irx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             empty,
  output logic             drop
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_ok, rd_ok;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign rd_ok = pop & ~empty;
  assign wr_ok = push & (~full | rd_ok);
  assign drop  = push & full & ~rd_ok;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wr_ok ? step(wptr_q) : wptr_q;
    rptr_d = rd_ok ? step(rptr_q) : rptr_q;
    cnt_d  = cnt_q;
    if (wr_ok && !rd_ok)      cnt_d = cnt_q + 1'b1;
    else if (rd_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= din;
  end

  assign dout = empty ? '0 : mem[rptr_q];
  assign cnt  = cnt_q;
endmodule

// File: rtl/irx_stat.sv
module irx_stat
  import irx_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int THRESH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ien_rx,
  input  logic             ien_err,
  output logic             ovr,
  output logic [7:0]       evt
);
  logic ovr_q, ovr_d;

  always_comb begin
    ovr_d = ovr_q;
    if (clr)  ovr_d = 1'b0;
    if (drop) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  always_comb begin
    evt = '0;
    evt[EVT_RX_BIT]  = ien_rx & (cnt >= CNT_W'(THRESH));
    evt[EVT_ERR_BIT] = ien_err & ovr_q;
  end

  assign ovr = ovr_q;
endmodule

// File: rtl/irx_rle_rx.sv
module irx_rle_rx
  import irx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int THRESH      = DEPTH / 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_tick,
  input  logic       ir_raw,
  input  logic       ir_invert,
  input  logic       rx_off,
  input  logic       ien_rx,
  input  logic       ien_err,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  logic [1:0]        rst_sh;
  logic              rst_q;
  logic              lvl;
  logic              enc_vld;
  irx_byte_t         enc_byte;
  logic              push, pop, clr;
  logic [BYTE_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_full, fifo_empty, drop;
  logic              ovr;
  logic [7:0]        evt;
  irx_reg_e          sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_q = rst_sh[1];

  irx_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .din(ir_raw), .inv(ir_invert), .lvl(lvl)
  );

  irx_run_enc u_enc (
    .clk(clk), .rst_n(rst_q), .tick(smp_tick), .lvl(lvl),
    .emit_vld(enc_vld), .emit_byte(enc_byte)
  );

  assign sel  = irx_reg_e'(rd_addr);
  assign push = enc_vld & ~rx_off;
  assign pop  = rd_en & (sel == REG_DATA);
  assign clr  = rd_en & (sel == REG_STAT);

  irx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_q), .push(push), .din(enc_byte), .pop(pop),
    .dout(fifo_dout), .cnt(fifo_cnt), .full(fifo_full),
    .empty(fifo_empty), .drop(drop)
  );

  irx_stat #(.CNT_W(CNT_W), .THRESH(THRESH)) u_stat (
    .clk(clk), .rst_n(rst_q), .drop(drop), .clr(clr), .cnt(fifo_cnt),
    .ien_rx(ien_rx), .ien_err(ien_err), .ovr(ovr), .evt(evt)
  );

  always_comb begin
    unique case (sel)
      REG_DATA: rd_data = fifo_dout;
      REG_STAT: rd_data = {6'b0, ovr, ~fifo_empty};
      REG_EVT:  rd_data = evt;
      default:  rd_data = 8'h00;
    endcase
  end

  assign irq = |evt;
endmodule

// File: rtl/irx_rle_rx_chk.sv
module irx_rle_rx_chk #(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_q,
  input logic             smp_tick,
  input logic             rx_off,
  input logic             enc_vld,
  input logic             fifo_full,
  input logic             pop,
  input logic             clr,
  input logic             drop,
  input logic             ovr,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             ien_rx,
  input logic             ien_err,
  input logic             irq
);
  AST_EMIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_q)
    enc_vld |-> $past(smp_tick)); // R2

  AST_FULL_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_q)
    (enc_vld && !rx_off && fifo_full && !pop) |=> ovr); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_q)
    fifo_cnt <= CNT_W'(DEPTH)); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_q)
    (clr && !drop) |=> !ovr); // R7

  AST_RX_EVT: assert property (@(posedge clk) disable iff (!rst_q)
    (ien_rx && fifo_cnt >= CNT_W'(THRESH)) |-> irq); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_q)
    (!ien_rx && !ien_err) |-> !irq); // R9

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_q)
    (rx_off && !pop) |=> $stable(fifo_cnt)); // R10
endmodule

bind irx_rle_rx irx_rle_rx_chk #(.DEPTH(DEPTH), .THRESH(THRESH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .smp_tick(smp_tick), .rx_off(rx_off),
  .enc_vld(enc_vld), .fifo_full(fifo_full), .pop(pop), .clr(clr),
  .drop(drop), .ovr(ovr), .fifo_cnt(fifo_cnt), .ien_rx(ien_rx),
  .ien_err(ien_err), .irq(irq)
);

// File: tb/sim_irx_rle_rx.sv
`timescale 1ns/1ps
module sim_irx_rle_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_tick = 1'b0;
  logic       ir_raw = 1'b0;
  logic       ir_invert = 1'b0;
  logic       rx_off = 1'b0;
  logic       ien_rx = 1'b0;
  logic       ien_err = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irx_rle_rx u0 (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .ir_raw(ir_raw),
    .ir_invert(ir_invert), .rx_off(rx_off), .ien_rx(ien_rx),
    .ien_err(ien_err), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); smp_tick = 1'b1;
    @(negedge clk); smp_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_ir(input logic v);
    @(negedge clk); ir_raw = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic toggles(input int n);
    for (int i = 0; i < n; i++) begin
      set_ir(~ir_raw);
      tick();
    end
  endtask

  task automatic drain();
    logic [7:0] d;
    for (int i = 0; i < 40; i++) begin
      rd(2'd1, d);
      if (d[0] == 1'b0) break;
      rd(2'd0, d);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd1, d); chk("R12 status", d, 8'h00);
    rd(2'd2, d); chk("R12 events", d, 8'h00);
    chk("R12 irq", {7'b0, irq}, 8'h00);
    rd(2'd0, d); chk("R11 empty data", d, 8'h00);
    rd(2'd1, d); chk("R11 empty read no effect", d, 8'h00);
  endtask

  task automatic t_format();
    logic [7:0] d;
    ticks(3);
    set_ir(1'b1);
    ticks(5);
    set_ir(1'b0);
    tick();
    rd(2'd1, d); chk("R7 avail", d, 8'h01);
    rd(2'd0, d); chk("R1 space run 3", d, 8'h82);
    rd(2'd0, d); chk("R1 pulse run 5", d, 8'h04);
    rd(2'd1, d); chk("R11 drained", d, 8'h00);
  endtask

  task automatic t_between_ticks();
    logic [7:0] d;
    set_ir(1'b1); repeat (5) @(negedge clk);
    set_ir(1'b0); repeat (5) @(negedge clk);
    tick();
    rd(2'd1, d); chk("R2 no byte between strobes", d, 8'h00);
  endtask

  task automatic t_long();
    logic [7:0] d;
    set_ir(1'b1);
    tick();
    drain();
    ticks(299);
    set_ir(1'b0);
    tick();
    rd(2'd0, d); chk("R3 chunk 1", d, 8'h7F);
    rd(2'd0, d); chk("R3 chunk 2", d, 8'h7F);
    rd(2'd0, d); chk("R3 remainder", d, 8'h2B);
    rd(2'd1, d); chk("R3 no extra", d, 8'h00);
  endtask

  task automatic t_exact128();
    logic [7:0] d;
    ticks(127);
    rd(2'd1, d); chk("R4 nothing before change", d, 8'h00);
    set_ir(1'b1);
    tick();
    rd(2'd0, d); chk("R4 single full byte", d, 8'hFF);
    rd(2'd1, d); chk("R4 only one byte", d, 8'h00);
  endtask

  task automatic t_invert();
    logic [7:0] d;
    @(negedge clk); ir_invert = 1'b1;
    tick();
    rd(2'd0, d); chk("R5 prior pulse", d, 8'h00);
    ticks(2);
    set_ir(1'b0);
    tick();
    rd(2'd0, d); chk("R5 inverted space", d, 8'h82);
    @(negedge clk); ir_invert = 1'b0;
    tick();
    drain();
  endtask

  task automatic t_threshold();
    logic [7:0] d;
    @(negedge clk); ien_rx = 1'b1;
    toggles(7);
    rd(2'd2, d); chk("R8 below threshold", d, 8'h00);
    chk("R9 irq low", {7'b0, irq}, 8'h00);
    toggles(1);
    rd(2'd2, d); chk("R8 at threshold", d, 8'h01);
    chk("R9 irq high", {7'b0, irq}, 8'h01);
    @(negedge clk); ien_rx = 1'b0;
    rd(2'd2, d); chk("R8 gated", d, 8'h00);
    chk("R9 irq gated", {7'b0, irq}, 8'h00);
    @(negedge clk); ien_rx = 1'b1;
    rd(2'd0, d);
    rd(2'd2, d); chk("R8 seven left", d, 8'h00);
    @(negedge clk); ien_rx = 1'b0;
    drain();
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    int n;
    @(negedge clk); ien_rx = 1'b1; ien_err = 1'b1;
    toggles(20);
    rd(2'd2, d); chk("R9 both events", d, 8'h05);
    chk("R9 irq", {7'b0, irq}, 8'h01);
    @(negedge clk); ien_err = 1'b0;
    rd(2'd2, d); chk("R9 err gated", d, 8'h01);
    @(negedge clk); ien_err = 1'b1;
    rd(2'd1, d); chk("R7 overrun and avail", d, 8'h03);
    rd(2'd1, d); chk("R7 overrun cleared", d, 8'h01);
    rd(2'd2, d); chk("R9 err gone", d, 8'h01);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      rd(2'd1, d);
      if (d[0] == 1'b0) break;
      rd(2'd0, d);
      n++;
      chk("R6 kept byte length", {1'b0, d[6:0]}, 8'h00);
    end
    chk("R6 sixteen kept", 8'(n), 8'd16);
    @(negedge clk); ien_rx = 1'b0; ien_err = 1'b0;
  endtask

  task automatic t_disable();
    logic [7:0] d;
    @(negedge clk); rx_off = 1'b1;
    toggles(4);
    rd(2'd1, d); chk("R10 nothing stored", d, 8'h00);
    @(negedge clk); rx_off = 1'b0;
    toggles(1);
    rd(2'd1, d); chk("R10 resumes", d, 8'h01);
    rd(2'd0, d); chk("R10 byte length", {1'b0, d[6:0]}, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_format();
    t_between_ticks();
    drain();
    t_long();
    t_exact128();
    t_invert();
    t_threshold();
    t_overrun();
    t_disable();
    summary();
  end
endmodule